// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block sits on the controller side of a double-data-rate memory interface. It takes write requests and turns each one into a WRITE command and the matching strobe and data activity. All activity is expressed in the core clock domain. Each core cycle carries one data pair, made of a word for the rising-strobe half and a word for the falling-strobe half. The strobe is described by two signals: one says whether it is driven, and one says whether it toggles in that cycle. The sequencer aims for the nominal one-clock delay from command to first rising strobe edge.

A request carries a bank, a start column, a burst-length code, an auto-precharge flag and the number of data pairs actually wanted. A later request may be issued as soon as the earlier burst has delivered its wanted pairs. If the earlier burst is longer than that, it is cut short. Otherwise the new burst follows on. In both cases the strobe keeps toggling without a break. A burst that is shortened but not followed by another request runs to its full length with the unwanted beats masked. After the last toggling cycle, a write-recovery counter keeps a busy flag raised. For a burst that asked for auto precharge, a one-cycle precharge-due pulse is raised when recovery ends.

Top module: `ddr_wr_burst_seq`

## Requirements
- R1: While reset is held and right after it is released, `req_ready` is 1 and `cmd_we`, `dqs_oe`, `dqs_tog`, `dq_oe`, `dm`, `wd_take`, `busy` and `pre_due` are 0.
- R2: A request accepted in cycle c (`req_valid` and `req_ready` both high) produces `cmd_we`=1 for exactly cycle c+1, with `cmd_bank`, `cmd_col` and `cmd_ap` equal to the request's fields.
- R3: After a command in cycle T whose request asked for p pairs, `req_ready` is low until cycle T+p-1 and high from then on. The earliest following command is therefore in cycle T+p.
- R4: In a command cycle in which the strobe is not already toggling, `dqs_oe`=1 and `dqs_tog`=0 (preamble).
- R5: For a command in cycle T with p wanted pairs, cycles T+1 to T+p have `dqs_tog`=1, `dq_oe`=1 and `dm`=0. They carry the pairs in request order, with `dq_rise`/`dq_fall` taken from `wd_rise`/`wd_fall` in the cycle before, when `wd_take` is 1. `wd_take` is high in exactly those preceding cycles.
- R6: If no command follows, the beats from p+1 up to the burst length toggle with `dm`=1 and `dq_rise`=`dq_fall`=0, and no data is taken for them.
- R7: A command issued at T+p makes its first beat land at T+p+1, directly after the last wanted beat of the earlier burst, with no cycle of idle strobe. Any remaining beats of the earlier burst are dropped.
- R8: In the cycle after the last toggling cycle, `dqs_oe` stays 1 with `dqs_tog`=0 (postamble). `dqs_oe` is 0 in every other non-command, non-toggling cycle.
- R9: `busy` is 1 in a command cycle and in every cycle within WR_CYC cycles after a toggling cycle (including the toggling cycle itself). It is 0 otherwise.
- R10: When the last toggling cycle E belongs to a burst with auto precharge, `pre_due` pulses for one cycle in cycle E+WR_CYC+1 with `pre_bank` equal to that burst's bank. There is no pulse if a command falls in cycle E+WR_CYC or E+WR_CYC+1. A truncated burst or a new command issued during recovery drops the pending precharge.
- R11: The burst-length code `req_len` gives the number of toggling cycles: 0 gives 1 pair (2 words), 1 gives 2 pairs, and 2 or 3 give 4 pairs. `req_pairs` must lie between 1 and that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_len | input | 2 | Burst-length code |
| req_pairs | input | 3 | Data pairs wanted from this burst |
| req_ap | input | 1 | Auto precharge after this burst |
| wd_take | output | 1 | Write pair on wd_rise/wd_fall consumed at next edge |
| wd_rise | input | DW | Write word for rising half |
| wd_fall | input | DW | Write word for falling half |
| cmd_we | output | 1 | WRITE command this cycle |
| cmd_bank | output | BANK_W | Command bank |
| cmd_col | output | COL_W | Command column |
| cmd_ap | output | 1 | Command auto-precharge bit |
| dqs_oe | output | 1 | Strobe driven |
| dqs_tog | output | 1 | Strobe toggles this cycle |
| dq_oe | output | 1 | Data lines driven |
| dq_rise | output | DW | Data word in rising half |
| dq_fall | output | DW | Data word in falling half |
| dm | output | 1 | Data mask for this pair |
| busy | output | 1 | Write burst or recovery in progress |
| pre_due | output | 1 | Auto precharge may now proceed |
| pre_bank | output | BANK_W | Bank for pre_due |

## Verification
The assertions assume that every accepted request carries a pair count of at least one and no larger than its burst length. They also assume the write-data source always has the next pair present when `wd_take` is high. The bench keeps to both conditions. Its request table only holds legal pair counts, and it presents a counting data pattern on every cycle. Its requests are held valid until accepted, with gaps chosen so that chained, truncated, masked-tail and recovery-interrupting sequences all occur.

// File: rtl/ddr_wseq_pkg.sv
package ddr_wseq_pkg;
  localparam int PAIR_W = 3;

  typedef enum logic [1:0] {
    BL2  = 2'd0,
    BL4  = 2'd1,
    BL8  = 2'd2,
    BL8X = 2'd3
  } blen_e;

  function automatic logic [PAIR_W-1:0] beats_of(blen_e b);
    case (b)
      BL2:     beats_of = PAIR_W'(1);
      BL4:     beats_of = PAIR_W'(2);
      default: beats_of = PAIR_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/wseq_cmd_gate.sv
module wseq_cmd_gate
  import ddr_wseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  blen_e             req_len,
  input  logic [PAIR_W-1:0] req_pairs,
  input  logic              req_ap,
  output logic              accept,
  output logic              cmd_we,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  output blen_e             cmd_len,
  output logic [PAIR_W-1:0] cmd_pairs
);
  logic [PAIR_W-1:0] gap_q, gap_n;

  assign req_ready = (gap_q <= PAIR_W'(1));
  assign accept    = req_valid & req_ready;

  always_comb begin
    gap_n = gap_q;
    if (accept)
      gap_n = req_pairs;
    else if (gap_q != '0)
      gap_n = gap_q - PAIR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_we    <= 1'b0;
      cmd_bank  <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      cmd_len   <= BL2;
      cmd_pairs <= '0;
    end else begin
      cmd_we <= accept;
      if (accept) begin
        cmd_bank  <= req_bank;
        cmd_col   <= req_col;
        cmd_ap    <= req_ap;
        cmd_len   <= req_len;
        cmd_pairs <= req_pairs;
      end
    end
  end

  // R3
  spacing_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_pairs > PAIR_W'(1)) |-> !req_ready);

  // R11
  legal_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_pairs != '0 && req_pairs <= beats_of(req_len)));
endmodule

// File: rtl/wseq_beat_engine.sv
module wseq_beat_engine
  import ddr_wseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  blen_e             cmd_len,
  input  logic [PAIR_W-1:0] cmd_pairs,
  input  logic [DW-1:0]     wd_rise,
  input  logic [DW-1:0]     wd_fall,
  output logic              wd_take,
  output logic              dqs_oe,
  output logic              dqs_tog,
  output logic              dq_oe,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dm
);
  logic [PAIR_W-1:0] beats_q, beats_n, keep_q, keep_n;
  logic              tog_q, tog_n, tog_d_q, dm_q, dm_n;
  logic [DW-1:0]     dr_q, dr_n, df_q, df_n;

  assign wd_take = cmd_we | (keep_q != '0);

  always_comb begin
    beats_n = '0;
    keep_n  = '0;
    tog_n   = 1'b0;
    dm_n    = 1'b0;
    dr_n    = '0;
    df_n    = '0;
    if (cmd_we) begin
      beats_n = beats_of(cmd_len) - PAIR_W'(1);
      keep_n  = cmd_pairs - PAIR_W'(1);
      tog_n   = 1'b1;
      dr_n    = wd_rise;
      df_n    = wd_fall;
    end else if (beats_q != '0) begin
      beats_n = beats_q - PAIR_W'(1);
      tog_n   = 1'b1;
      if (keep_q != '0) begin
        keep_n = keep_q - PAIR_W'(1);
        dr_n   = wd_rise;
        df_n   = wd_fall;
      end else begin
        dm_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q <= '0;
      keep_q  <= '0;
      tog_q   <= 1'b0;
      tog_d_q <= 1'b0;
      dm_q    <= 1'b0;
      dr_q    <= '0;
      df_q    <= '0;
    end else begin
      beats_q <= beats_n;
      keep_q  <= keep_n;
      tog_q   <= tog_n;
      tog_d_q <= tog_q;
      dm_q    <= dm_n;
      dr_q    <= dr_n;
      df_q    <= df_n;
    end
  end

  assign dqs_tog = tog_q;
  assign dq_oe   = tog_q;
  assign dqs_oe  = cmd_we | tog_q | tog_d_q;
  assign dm      = dm_q;
  assign dq_rise = dr_q;
  assign dq_fall = df_q;

  // R4
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !dqs_tog) |-> (dqs_oe && !dq_oe));

  // R7
  chain_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (dqs_tog && !dm));

  // R5
  take_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_take |=> (dq_oe && !dm));

  // R8
  postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_tog) |-> dqs_oe);
endmodule

// File: rtl/wseq_recovery.sv
module wseq_recovery #(
  parameter int BANK_W = 2,
  parameter int WR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cmd_we,
  input  logic              cmd_ap,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              dqs_tog,
  output logic              busy,
  output logic              pre_due,
  output logic [BANK_W-1:0] pre_bank
);
  localparam int REC_W = $clog2(WR_CYC + 1);

  logic [REC_W-1:0]  rec_q, rec_n;
  logic              arm_q, pre_q, fire;
  logic [BANK_W-1:0] arm_bank_q, pre_bank_q;

  assign fire = arm_q && (rec_q == REC_W'(1)) && !dqs_tog && !cmd_we && !accept;

  always_comb begin
    rec_n = rec_q;
    if (dqs_tog)
      rec_n = REC_W'(WR_CYC);
    else if (rec_q != '0)
      rec_n = rec_q - REC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q      <= '0;
      arm_q      <= 1'b0;
      arm_bank_q <= '0;
      pre_q      <= 1'b0;
      pre_bank_q <= '0;
    end else begin
      rec_q <= rec_n;
      pre_q <= fire;
      if (cmd_we) begin
        arm_q      <= cmd_ap;
        arm_bank_q <= cmd_bank;
      end else if (fire) begin
        arm_q <= 1'b0;
      end
      if (fire)
        pre_bank_q <= arm_bank_q;
    end
  end

  assign busy     = cmd_we | dqs_tog | (rec_q != '0);
  assign pre_due  = pre_q;
  assign pre_bank = pre_bank_q;

  // R9
  busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_tog |=> busy);

  // R10
  pre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_due |-> (!busy && !dqs_tog && !cmd_we));
endmodule

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq
  import ddr_wseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DW     = 8,
  parameter int WR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_len,
  input  logic [2:0]        req_pairs,
  input  logic              req_ap,
  output logic              wd_take,
  input  logic [DW-1:0]     wd_rise,
  input  logic [DW-1:0]     wd_fall,
  output logic              cmd_we,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_ap,
  output logic              dqs_oe,
  output logic              dqs_tog,
  output logic              dq_oe,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dm,
  output logic              busy,
  output logic              pre_due,
  output logic [BANK_W-1:0] pre_bank
);
  logic              accept;
  blen_e             cmd_len;
  logic [PAIR_W-1:0] cmd_pairs;

  wseq_cmd_gate #(.BANK_W(BANK_W), .COL_W(COL_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col),
    .req_len(blen_e'(req_len)), .req_pairs(PAIR_W'(req_pairs)), .req_ap(req_ap),
    .accept(accept), .cmd_we(cmd_we), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .cmd_len(cmd_len), .cmd_pairs(cmd_pairs)
  );

  wseq_beat_engine #(.DW(DW)) u_beats (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_len(cmd_len), .cmd_pairs(cmd_pairs),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wd_take(wd_take),
    .dqs_oe(dqs_oe), .dqs_tog(dqs_tog), .dq_oe(dq_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm(dm)
  );

  wseq_recovery #(.BANK_W(BANK_W), .WR_CYC(WR_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .cmd_we(cmd_we), .cmd_ap(cmd_ap), .cmd_bank(cmd_bank),
    .dqs_tog(dqs_tog), .busy(busy), .pre_due(pre_due), .pre_bank(pre_bank)
  );
endmodule

// File: tb/sim_ddr_wr_burst_seq.sv
module sim_ddr_wr_burst_seq;
  localparam int BANK_W = 2;
  localparam int COL_W  = 10;
  localparam int DW     = 8;
  localparam int WR     = 3;
  localparam int N      = 1024;
  localparam int NR     = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, req_valid, req_ready, req_ap, wd_take;
  logic [BANK_W-1:0] req_bank, cmd_bank, pre_bank;
  logic [COL_W-1:0]  req_col, cmd_col;
  logic [1:0]        req_len;
  logic [2:0]        req_pairs;
  logic [DW-1:0]     wd_rise, wd_fall, dq_rise, dq_fall;
  logic              cmd_we, cmd_ap, dqs_oe, dqs_tog, dq_oe, dm, busy, pre_due;

  ddr_wr_burst_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .DW(DW), .WR_CYC(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_pairs(req_pairs),
    .req_ap(req_ap), .wd_take(wd_take), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .cmd_we(cmd_we), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .dqs_oe(dqs_oe), .dqs_tog(dqs_tog), .dq_oe(dq_oe), .dq_rise(dq_rise),
    .dq_fall(dq_fall), .dm(dm), .busy(busy), .pre_due(pre_due), .pre_bank(pre_bank)
  );

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // request table: idle cycles before, bank, column, length code, pairs, auto precharge
  int q_gap [NR] = '{2, 8, 10, 0, 0, 10, 0, 0, 8, 3, 3, 12};
  int q_bank[NR] = '{1, 2, 0, 3, 1, 2, 0, 3, 1, 2, 3, 0};
  int q_col [NR] = '{16, 32, 48, 50, 52, 64, 72, 76, 128, 136, 140, 200};
  int q_len [NR] = '{1, 2, 0, 0, 0, 2, 1, 1, 1, 1, 0, 2};
  int q_pr  [NR] = '{2, 4, 1, 1, 1, 2, 2, 1, 2, 2, 1, 3};
  int q_ap  [NR] = '{0, 1, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1};

  // behavioural reference: per-cycle expectations
  bit e_cmd[N], e_tog[N], e_dm[N], e_ap[N];
  int e_dr[N], e_df[N], e_bk[N], e_cb[N], e_cc[N], e_ca[N];
  int lastT, lastP, midx, didx;
  int nchk, nfail;

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", rq, cyc, act, exp);
    end
  endtask

  task automatic model_accept(input int c, input int r);
    int t, n;
    t = c + 1;
    n = (q_len[r] == 0) ? 1 : (q_len[r] == 1) ? 2 : 4;
    e_cmd[t] = 1'b1; e_cb[t] = q_bank[r]; e_cc[t] = q_col[r]; e_ca[t] = q_ap[r];
    for (int k = 1; k <= 8; k++) begin
      e_tog[t+k] = 1'b0; e_dm[t+k] = 1'b0; e_dr[t+k] = 0; e_df[t+k] = 0; e_ap[t+k] = 1'b0;
    end
    for (int k = 1; k <= n; k++) begin
      e_tog[t+k] = 1'b1;
      e_ap[t+k]  = q_ap[r] != 0;
      e_bk[t+k]  = q_bank[r];
      if (k <= q_pr[r]) begin
        e_dr[t+k] = (2*midx + 1) % 256;
        e_df[t+k] = (2*midx + 2) % 256;
        midx++;
      end else begin
        e_dm[t+k] = 1'b1;
      end
    end
    lastT = t;
    lastP = q_pr[r];
  endtask

  initial begin
    int ri, wait_cnt, idle, c, e;
    bit ex_rdy, ex_take, ex_busy, ex_pre, quiet;
    nchk = 0; nfail = 0; midx = 0; didx = 0;
    lastT = -100; lastP = 1;
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_len = '0;
    req_pairs = '0; req_ap = 1'b0; wd_rise = '0; wd_fall = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 cmd_we", int'(cmd_we), 0);
    chk("R1 dqs_oe", int'(dqs_oe), 0);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 wd_take", int'(wd_take), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 pre_due", int'(pre_due), 0);
    rst_n = 1'b1;
    ri = 0; wait_cnt = q_gap[0]; idle = 0;
    while (idle < 30) begin
      c = cyc;
      if (c > 900) begin
        nfail++;
        $display("FAIL R3 watchdog expired cyc=%0d", c);
        break;
      end
      // expected values for cycle c
      ex_rdy  = (c >= lastT + lastP - 1);
      ex_take = e_tog[c+1] && !e_dm[c+1];
      ex_busy = e_cmd[c];
      for (int k = 0; k <= WR; k++) if (c - k >= 0 && e_tog[c-k]) ex_busy = 1'b1;
      ex_pre = 1'b0;
      e = c - 1 - WR;
      if (e >= 0 && e_tog[e] && e_ap[e] && !e_cmd[c-1] && !e_cmd[c]) begin
        quiet = 1'b1;
        for (int k = e + 1; k <= c; k++) if (e_tog[k]) quiet = 1'b0;
        ex_pre = quiet;
      end
      chk("R3 ready", int'(req_ready), int'(ex_rdy));
      chk("R2 cmd_we", int'(cmd_we), int'(e_cmd[c]));
      if (e_cmd[c]) begin
        chk("R2 cmd_bank", int'(cmd_bank), e_cb[c]);
        chk("R2 cmd_col", int'(cmd_col), e_cc[c]);
        chk("R2 cmd_ap", int'(cmd_ap), e_ca[c]);
      end
      if (c > 0 && e_tog[c-1] && e_tog[c]) chk("R7 strobe continuous", int'(dqs_tog), 1);
      else chk("R11 strobe toggle", int'(dqs_tog), int'(e_tog[c]));
      chk("R5 dq_oe", int'(dq_oe), int'(e_tog[c]));
      if (e_cmd[c] && !e_tog[c]) chk("R4 preamble", int'(dqs_oe), 1);
      else if (c > 0 && e_tog[c-1] && !e_tog[c]) chk("R8 postamble", int'(dqs_oe), 1);
      else chk("R8 strobe drive", int'(dqs_oe), int'(e_tog[c]));
      if (e_tog[c]) begin
        chk(e_dm[c] ? "R6 mask" : "R5 mask", int'(dm), int'(e_dm[c]));
        chk(e_dm[c] ? "R6 dq_rise" : "R5 dq_rise", int'(dq_rise), e_dr[c]);
        chk(e_dm[c] ? "R6 dq_fall" : "R5 dq_fall", int'(dq_fall), e_df[c]);
      end
      chk("R5 wd_take", int'(wd_take), int'(ex_take));
      chk("R9 busy", int'(busy), int'(ex_busy));
      chk("R10 pre_due", int'(pre_due), int'(ex_pre));
      if (ex_pre) chk("R10 pre_bank", int'(pre_bank), e_bk[e]);
      // drive write data for this cycle
      wd_rise = DW'((2*didx + 1) % 256);
      wd_fall = DW'((2*didx + 2) % 256);
      if (ex_take) didx++;
      // drive requests
      if (ri < NR) begin
        if (wait_cnt > 0) begin
          req_valid = 1'b0;
          wait_cnt--;
        end else begin
          req_valid = 1'b1;
          req_bank  = BANK_W'(q_bank[ri]);
          req_col   = COL_W'(q_col[ri]);
          req_len   = 2'(q_len[ri]);
          req_pairs = 3'(q_pr[ri]);
          req_ap    = q_ap[ri] != 0;
          if (ex_rdy) begin
            model_accept(c, ri);
            ri++;
            if (ri < NR) wait_cnt = q_gap[ri];
          end
        end
      end else begin
        req_valid = 1'b0;
        idle++;
      end
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule